// File: doc/BRIEF.md
# Two-Level Nested Row/Column Thermometer Decoder

This block turns a 12-bit binary code into one enable bit per unit cell of a current-steering array. The array has two levels. At the top it is an 8x8 grid of matrices. Each matrix is itself an 8x8 grid of cells. The result is 4096 enable lines, and the number of lines that are high always equals the input code.

The code is cut into four 3-bit fields. Each field feeds a small thermometer decoder. Every decoder produces two sets of lines: "below" lines, which mark positions lower than the field value, and "at" lines, which mark the position equal to it.

The two upper fields sort the matrices into three kinds: fully on, fully off, or the single partial matrix. The two lower fields are shared by every matrix. Each cell combines the shared row and column lines with its own matrix's kind to decide whether it is on. The enable vector is registered, and it appears one clock after the code is sampled.

Top module: `nested_therm_decoder`

## Requirements
- R1: Field layout of `code_i`. Bits [2:0] give the cell column inside a matrix. Bits [5:3] give the cell row inside a matrix. Bits [8:6] give the matrix column. Bits [11:9] give the matrix row.
- R2: Each field value k drives its decoder's below lines 0..k-1 high. Exactly one of the decoder's at lines is high, and that line is line k.
- R3: Matrix index = matrix_row*8 + matrix_column. Every matrix whose index is less than code[11:6] has all 64 of its cells enabled.
- R4: Exactly one matrix is partial, and its index equals code[11:6]. Every matrix with a higher index has all of its cells disabled.
- R5: Inside the partial matrix, the cell at row r, column c is on when r < code[5:3]. It is also on when r == code[5:3] and c < code[2:0]. Otherwise it is off.
- R6: Cell bit index = matrix_index*64 + row*8 + column. The enabled bits form a contiguous run starting at bit 0, and the run length equals the code.
- R7: `cell_en_o` reflects the code sampled at the previous rising clock edge. A change on `code_i` between edges does not reach the output before the next edge.
- R8: A synchronous active-high `rst` clears every bit of `cell_en_o` to 0 at the next edge.
- R9: Bit 4095 of `cell_en_o` is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 12 | Binary code to decode |
| cell_en_o | output | 4096 | Registered per-cell enable vector |

## Verification
The hardest situations to reach from the ports are the boundaries between matrices: codes whose low six bits are zero, where the partial matrix is completely dark, and codes whose low six bits are all ones, where only its last cell is off. Both cases sit at every 64th code. A full ascending sweep of all 4096 codes reaches each of them. Seeded random codes then cover large jumps between distant codes. Directed codes isolate one field at a time, and mid-cycle code changes probe the register timing.

// File: rtl/nrc_pkg.sv
package nrc_pkg;
  // Classification of one matrix at the upper decoding level
  typedef enum logic [1:0] {
    MAT_OFF  = 2'd0,
    MAT_FULL = 2'd1,
    MAT_PART = 2'd2
  } mat_kind_e;
endpackage

// File: rtl/nrc_thermo_dec.sv
// Field decoder: "below" lines are a thermometer, "at" lines one-hot.
module nrc_thermo_dec #(
  parameter int FIELD_W = 3,
  localparam int LINES  = 1 << FIELD_W
) (
  input  logic [FIELD_W-1:0] val_i,
  output logic [LINES-1:0]   below_o,
  output logic [LINES-1:0]   at_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign below_o[i] = (int'(val_i) > i);
    if (i == 0) begin : g_first
      assign at_o[i] = ~below_o[i];
    end else begin : g_rest
      assign at_o[i] = below_o[i-1] & ~below_o[i];
    end
  end
endmodule

// File: rtl/nrc_matrix.sv
// One matrix: upper-level kind decision plus local cell logic.
module nrc_matrix
  import nrc_pkg::*;
#(
  parameter int FIELD_W = 3,
  localparam int LINES  = 1 << FIELD_W,
  localparam int CELLS  = LINES * LINES
) (
  input  logic             mrow_below_i,
  input  logic             mrow_at_i,
  input  logic             mcol_below_i,
  input  logic             mcol_at_i,
  input  logic [LINES-1:0] crow_below_i,
  input  logic [LINES-1:0] crow_at_i,
  input  logic [LINES-1:0] ccol_below_i,
  output mat_kind_e        kind_o,
  output logic [CELLS-1:0] cells_o
);
  always_comb begin
    if (mrow_below_i || (mrow_at_i && mcol_below_i))
      kind_o = MAT_FULL;
    else if (mrow_at_i && mcol_at_i)
      kind_o = MAT_PART;
    else
      kind_o = MAT_OFF;
  end

  for (genvar r = 0; r < LINES; r++) begin : g_row
    always_comb begin
      if (kind_o == MAT_FULL || (kind_o == MAT_PART && crow_below_i[r]))
        cells_o[r*LINES +: LINES] = '1;
      else if (kind_o == MAT_PART && crow_at_i[r])
        cells_o[r*LINES +: LINES] = ccol_below_i;
      else
        cells_o[r*LINES +: LINES] = '0;
    end
  end
endmodule

// File: rtl/nested_therm_decoder.sv
module nested_therm_decoder
  import nrc_pkg::*;
#(
  parameter int FIELD_W = 3,
  localparam int LINES  = 1 << FIELD_W,
  localparam int CELLS  = LINES * LINES,
  localparam int MATS   = LINES * LINES,
  localparam int CODE_W = 4 * FIELD_W,
  localparam int TOTAL  = CELLS * MATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output logic [TOTAL-1:0]  cell_en_o
);
  logic [LINES-1:0] crow_below, crow_at, ccol_below, ccol_at;
  logic [LINES-1:0] mrow_below, mrow_at, mcol_below, mcol_at;
  logic [TOTAL-1:0] en_next;
  logic [MATS-1:0]  full_vec, part_vec;

  // Cell column, cell row, matrix column, matrix row (low to high)
  nrc_thermo_dec #(.FIELD_W(FIELD_W)) u_ccol (
    .val_i(code_i[FIELD_W-1:0]), .below_o(ccol_below), .at_o(ccol_at));
  nrc_thermo_dec #(.FIELD_W(FIELD_W)) u_crow (
    .val_i(code_i[2*FIELD_W-1:FIELD_W]), .below_o(crow_below), .at_o(crow_at));
  nrc_thermo_dec #(.FIELD_W(FIELD_W)) u_mcol (
    .val_i(code_i[3*FIELD_W-1:2*FIELD_W]), .below_o(mcol_below), .at_o(mcol_at));
  nrc_thermo_dec #(.FIELD_W(FIELD_W)) u_mrow (
    .val_i(code_i[4*FIELD_W-1:3*FIELD_W]), .below_o(mrow_below), .at_o(mrow_at));

  for (genvar mr = 0; mr < LINES; mr++) begin : g_mrow
    for (genvar mc = 0; mc < LINES; mc++) begin : g_mcol
      localparam int M = mr * LINES + mc;
      mat_kind_e kind;
      nrc_matrix #(.FIELD_W(FIELD_W)) u_mat (
        .mrow_below_i(mrow_below[mr]),
        .mrow_at_i   (mrow_at[mr]),
        .mcol_below_i(mcol_below[mc]),
        .mcol_at_i   (mcol_at[mc]),
        .crow_below_i(crow_below),
        .crow_at_i   (crow_at),
        .ccol_below_i(ccol_below),
        .kind_o      (kind),
        .cells_o     (en_next[M*CELLS +: CELLS])
      );
      assign full_vec[M] = (kind == MAT_FULL);
      assign part_vec[M] = (kind == MAT_PART);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cell_en_o <= '0;
    else     cell_en_o <= en_next;
  end

  // Decoder at-lines are one-hot for every field
  assert_at_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(ccol_at) && $onehot(crow_at) && $onehot(mcol_at) && $onehot(mrow_at));

  assert_full_count_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(full_vec) == int'(code_i[CODE_W-1:2*FIELD_W]));

  assert_one_partial_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot(part_vec) && ((full_vec & part_vec) == '0));

  assert_popcount_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(cell_en_o) == int'($past(code_i)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (cell_en_o == '0));

  assert_top_off_R9: assert property (@(posedge clk) disable iff (rst)
    !cell_en_o[TOTAL-1]);
endmodule

// File: tb/tb_nested_therm_decoder.sv
module tb_nested_therm_decoder;
  localparam int TOTAL = 4096;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [11:0]      code = '0;
  logic [TOTAL-1:0] dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  nested_therm_decoder dut (.clk(clk), .rst(rst), .code_i(code), .cell_en_o(dout));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [TOTAL-1:0] exp_vec(input int c);
    logic [TOTAL-1:0] v;
    for (int i = 0; i < TOTAL; i++) v[i] = (i < c);
    return v;
  endfunction

  // Full structural check of the output for code c
  task automatic check_out(input int c);
    int nfull;
    int m;
    logic [63:0] ps;
    bit hi_zero;
    chk(dout == exp_vec(c), "R6 prefix", $countones(dout), c);
    chk($countones(dout) == c, "R6 popcount", $countones(dout), c);
    chk(dout[TOTAL-1] == 1'b0, "R9 top bit", int'(dout[TOTAL-1]), 0);
    nfull = 0;
    for (int k = 0; k < 64; k++) if (&dout[k*64 +: 64]) nfull++;
    chk(nfull == (c >> 6), "R3 full matrices", nfull, c >> 6);
    m  = c >> 6;
    ps = dout[m*64 +: 64];
    chk(ps == (64'(1) << (c & 63)) - 64'(1), "R5 partial matrix", $countones(ps), c & 63);
    hi_zero = 1'b1;
    for (int k = m + 1; k < 64; k++) if (|dout[k*64 +: 64]) hi_zero = 1'b0;
    chk(hi_zero, "R4 upper matrices off", int'(hi_zero), 1);
  endtask

  task automatic apply(input int c);
    @(negedge clk);
    code = 12'(c);
    @(negedge clk);
    check_out(c);
  endtask

  initial begin
    for (int cyc = 0; cyc < 200000; cyc++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(dout == '0, "R8 reset state", $countones(dout), 0);
    rst = 1'b0;

    // Ascending sweep over every code, including all matrix boundaries
    for (int c = 0; c < TOTAL; c++) apply(c);

    // R1/R2: one field at a time
    for (int k = 0; k < 8; k++) begin
      apply(k);                                  // cell column field
      chk($countones(dout[63:0]) == k, "R1 column field", $countones(dout[63:0]), k);
      apply(k << 3);                             // cell row field
      chk($countones(dout[63:0]) == 8 * k, "R2 row lines", $countones(dout[63:0]), 8 * k);
      apply(k << 6);                             // matrix column field
      chk(dout[k*64] == 1'b0 && (k == 0 || dout[k*64-1]), "R1 matrix column field",
          int'(dout[k*64]), 0);
      apply(k << 9);                             // matrix row field
      chk(dout[k*512] == 1'b0 && (k == 0 || dout[k*512-1]), "R1 matrix row field",
          int'(dout[k*512]), 0);
    end

    // Seeded random codes with large jumps
    for (int n = 0; n < 400; n++) apply(int'($urandom() & 32'hFFF));

    // R7: mid-cycle change is not visible before the next edge
    apply(100);
    @(negedge clk);
    code = 12'd3000;
    #3;
    chk($countones(dout) == 100, "R7 latency hold", $countones(dout), 100);
    @(negedge clk);
    chk($countones(dout) == 3000, "R7 latency update", $countones(dout), 3000);

    // R8: reset in the middle of operation
    apply(4095);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(dout == '0, "R8 mid-run reset", $countones(dout), 0);
    rst = 1'b0;
    apply(63);
    apply(64);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule